// File: doc/BRIEF.md
# Row-Based Reorder Buffer Allocator

This block tracks the occupancy of a reorder buffer built from rows of seven instruction slots. Instructions arrive in program order, one per cycle, and are placed into the row currently open at the tail. Retirement frees whole rows from the head, never single slots. The row is therefore the unit of both allocation bookkeeping and release.

An instruction that can redirect the pipeline (a branch, load or store) is always placed in the final slot of its row. That placement closes the row at once, and any slots skipped on the way stay empty for good. A short sequence such as add, mov, store therefore fills a whole row. A stream made only of such instructions holds one instruction per row, so the row count is then the whole capacity. Completion reports arrive by row and slot number. Every cycle the block reports how many rows it frees from the head, up to a fixed per-cycle limit. It raises a stall when an instruction would need a new row and none is free.

Top module: `rob_row_buffer`

## Requirements
- R1: An instruction that cannot redirect the pipeline takes the next unused slot of the open row, starting at slot 0. Writing slot 6 closes the row, and the next instruction opens a new row at slot 0.
- R2: A redirect-capable instruction (alloc_flush=1) is placed in slot 6, the last slot, of the open row, or of a freshly opened row when none is open, and closes that row. Skipped slots stay unused, so add, mov, store occupy slots 0, 1 and 6 of one row.
- R3: New rows are opened in ascending circular order, row 0 first after reset, then row 1, and so on up to ROWS-1 (15 by default), then row 0 again.
- R4: alloc_stall is high exactly when no row is open and all ROWS rows are allocated. While it is high no instruction is accepted. With a stream of only redirect-capable instructions, exactly ROWS instructions fit.
- R5: A row is ready to retire only when it is closed and every occupied slot has completed. Unused slots count as complete. An open row never retires.
- R6: retire_rows counts the ready rows taken in order from the head row, given on retire_head. The count stops at the first row that is not ready and never exceeds RETIRE_MAX (8 by default). Both outputs follow the current state in the same cycle.
- R7: rows_used counts allocated rows, including the open one. At the next clock edge the reported rows are freed, rows_used drops by retire_rows, and retire_head advances by that amount modulo ROWS.
- R8: A completion naming a free row, or a slot of an allocated row that holds no instruction, has no effect. A later instruction placed there still needs its own completion.
- R9: After reset, rows_used is 0, alloc_stall is 0, retire_rows is 0, retire_head is 0, and the next instruction goes to row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | An instruction is offered for allocation |
| alloc_flush | input | 1 | The offered instruction can redirect the pipeline |
| alloc_stall | output | 1 | No free row for an instruction that needs one; offer not taken |
| alloc_row | output | ROW_W (4) | Row the offered instruction is placed in |
| alloc_slot | output | SLOT_W (3) | Slot the offered instruction is placed in |
| cpl_valid | input | 1 | A completion report is present |
| cpl_row | input | ROW_W (4) | Row of the completed instruction |
| cpl_slot | input | SLOT_W (3) | Slot of the completed instruction |
| retire_rows | output | CNT_W (4) | Rows freed at the coming edge |
| retire_head | output | ROW_W (4) | Row at the head, the first one freed |
| rows_used | output | USED_W (5) | Number of allocated rows |

## Verification
Placement, alloc_stall and alloc_row/alloc_slot follow the current state and inputs within the same cycle. A completion accepted at one edge can raise retire_rows just after that edge. The rows it reports leave rows_used and move retire_head only at the following edge. The bench drives inputs after each falling edge and samples all outputs one time unit later, before the rising edge. A row-rule model in the bench then advances once per rising edge, so each comparison sees exactly the register updates already committed.

// File: rtl/rob_row_pkg.sv
// Shared types and helpers for the row-based reorder buffer allocator.
// Assumes all ring indices fit in a 32-bit unsigned integer.
package rob_row_pkg;

    // State of the tail row: whether an allocated row still takes instructions
    typedef enum logic {
        TAIL_SHUT = 1'b0,
        TAIL_OPEN = 1'b1
    } tail_state_e;

    // Circular increment of a row index
    function automatic int unsigned ring_add(int unsigned base, int unsigned inc,
                                             int unsigned ring);
        return (base + inc) % ring;
    endfunction

endpackage

// File: rtl/rob_row_alloc.sv
// Tail-row controller. Decides the row and slot for the offered instruction,
// opens new rows in circular order and closes a row when its last slot is
// written. Assumes at most one instruction per cycle, in program order.
module rob_row_alloc
    import rob_row_pkg::*;
#(
    parameter int ROWS   = 16,
    parameter int SLOTS  = 7,
    parameter int ROW_W  = 4,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic              alloc_flush,
    input  logic              rows_full,
    output logic              stall,
    output logic              accept,
    output logic              opens_row,
    output logic              close_row,
    output logic [ROW_W-1:0]  row,
    output logic [SLOT_W-1:0] slot
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    tail_state_e       state_q;
    logic [ROW_W-1:0]  cur_q;
    logic [ROW_W-1:0]  next_q;
    logic [SLOT_W-1:0] fill_q;
    logic [SLOT_W-1:0] base_fill;

    // Placement decision for the offered instruction
    always_comb begin
        opens_row = (state_q == TAIL_SHUT);
        base_fill = opens_row ? '0 : fill_q;
        stall     = opens_row && rows_full;
        accept    = alloc_valid && !stall;
        row       = opens_row ? next_q : cur_q;
        slot      = alloc_flush ? LAST_SLOT : base_fill;
        close_row = alloc_flush || (base_fill == LAST_SLOT);
    end

    // Tail row state update on an accepted instruction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TAIL_SHUT;
            cur_q   <= '0;
            next_q  <= '0;
            fill_q  <= '0;
        end else if (accept) begin
            if (opens_row) begin
                cur_q  <= next_q;
                next_q <= ROW_W'(ring_add(int'(next_q), 1, ROWS));
            end
            state_q <= close_row ? TAIL_SHUT : TAIL_OPEN;
            fill_q  <= close_row ? '0 : base_fill + SLOT_W'(1);
        end
    end

endmodule

// File: rtl/rob_row_table.sv
// Per-row slot table. Keeps, for each row, whether it is allocated and
// closed, which slots hold instructions and which have completed. Reports a
// ready flag per row. Assumes the retire path never frees the row that the
// allocator opens in the same cycle.
module rob_row_table #(
    parameter int ROWS   = 16,
    parameter int SLOTS  = 7,
    parameter int ROW_W  = 4,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_new,
    input  logic              wr_close,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              cpl_valid,
    input  logic [ROW_W-1:0]  cpl_row,
    input  logic [SLOT_W-1:0] cpl_slot,
    input  logic [ROWS-1:0]   free_mask,
    output logic [ROWS-1:0]   row_ready
);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic             valid_q;
        logic             closed_q;
        logic [SLOTS-1:0] occ_q;
        logic [SLOTS-1:0] done_q;
        logic             hit_wr;
        logic [SLOTS-1:0] set_mask;
        logic [SLOTS-1:0] cpl_mask;

        // Write and completion masks that address this row
        always_comb begin
            hit_wr   = wr_en && (wr_row == ROW_W'(r));
            set_mask = hit_wr ? (SLOTS'(1) << wr_slot) : '0;
            cpl_mask = (cpl_valid && valid_q && (cpl_row == ROW_W'(r)))
                       ? ((SLOTS'(1) << cpl_slot) & occ_q) : '0;
        end

        // Row bookkeeping: free, open, fill and completion
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q  <= 1'b0;
                closed_q <= 1'b0;
                occ_q    <= '0;
                done_q   <= '0;
            end else if (free_mask[r]) begin
                valid_q  <= 1'b0;
                closed_q <= 1'b0;
                occ_q    <= '0;
                done_q   <= '0;
            end else if (hit_wr && wr_new) begin
                valid_q  <= 1'b1;
                closed_q <= wr_close;
                occ_q    <= set_mask;
                done_q   <= '0;
            end else begin
                occ_q  <= occ_q | set_mask;
                done_q <= (done_q & ~set_mask) | cpl_mask;
                if (hit_wr && wr_close) begin
                    closed_q <= 1'b1;
                end
            end
        end

        assign row_ready[r] = valid_q && closed_q && (&(done_q | ~occ_q));
    end

endmodule

// File: rtl/rob_row_retire.sv
// In-order retire scan. Walks forward from the head row and counts ready
// rows, stopping at the first row that is not ready, at the number of
// allocated rows, or at the per-cycle limit. Assumes RETIRE_MAX <= ROWS.
module rob_row_retire #(
    parameter int ROWS       = 16,
    parameter int RETIRE_MAX = 8,
    parameter int ROW_W      = 4,
    parameter int CNT_W      = 4,
    parameter int USED_W     = 5
) (
    input  logic [ROW_W-1:0]  head,
    input  logic [USED_W-1:0] used,
    input  logic [ROWS-1:0]   row_ready,
    output logic [CNT_W-1:0]  count,
    output logic [ROWS-1:0]   free_mask
);

    // Ordered scan from the head row
    always_comb begin
        logic go;
        int   idx;
        go        = 1'b1;
        count     = '0;
        free_mask = '0;
        for (int i = 0; i < RETIRE_MAX; i++) begin
            idx = (int'(head) + i) % ROWS;
            if (go && (i < int'(used)) && row_ready[idx]) begin
                count          = count + CNT_W'(1);
                free_mask[idx] = 1'b1;
            end else begin
                go = 1'b0;
            end
        end
    end

endmodule

// File: rtl/rob_row_buffer.sv
// Top level of the row-based reorder buffer allocator. Joins the tail-row
// controller, the per-row slot table and the retire scan, and keeps the head
// row and the allocated row count. Assumes one allocation and one completion
// per cycle.
module rob_row_buffer
    import rob_row_pkg::*;
#(
    parameter int ROWS       = 16,
    parameter int SLOTS      = 7,
    parameter int RETIRE_MAX = 8,
    localparam int ROW_W     = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CNT_W     = $clog2(RETIRE_MAX + 1),
    localparam int USED_W    = $clog2(ROWS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic              alloc_flush,
    output logic              alloc_stall,
    output logic [ROW_W-1:0]  alloc_row,
    output logic [SLOT_W-1:0] alloc_slot,
    input  logic              cpl_valid,
    input  logic [ROW_W-1:0]  cpl_row,
    input  logic [SLOT_W-1:0] cpl_slot,
    output logic [CNT_W-1:0]  retire_rows,
    output logic [ROW_W-1:0]  retire_head,
    output logic [USED_W-1:0] rows_used
);

    logic [ROW_W-1:0]  head_q;
    logic [USED_W-1:0] used_q;
    logic              rows_full;
    logic              accept;
    logic              opens_row;
    logic              close_row;
    logic              new_row_taken;
    logic [ROWS-1:0]   row_ready;
    logic [ROWS-1:0]   free_mask;
    logic [CNT_W-1:0]  ret_cnt;

    assign rows_full     = (used_q == USED_W'(ROWS));
    assign new_row_taken = accept && opens_row;

    rob_row_alloc #(
        .ROWS(ROWS), .SLOTS(SLOTS), .ROW_W(ROW_W), .SLOT_W(SLOT_W)
    ) u_alloc (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_valid(alloc_valid),
        .alloc_flush(alloc_flush),
        .rows_full  (rows_full),
        .stall      (alloc_stall),
        .accept     (accept),
        .opens_row  (opens_row),
        .close_row  (close_row),
        .row        (alloc_row),
        .slot       (alloc_slot)
    );

    rob_row_table #(
        .ROWS(ROWS), .SLOTS(SLOTS), .ROW_W(ROW_W), .SLOT_W(SLOT_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (accept),
        .wr_new   (opens_row),
        .wr_close (close_row),
        .wr_row   (alloc_row),
        .wr_slot  (alloc_slot),
        .cpl_valid(cpl_valid),
        .cpl_row  (cpl_row),
        .cpl_slot (cpl_slot),
        .free_mask(free_mask),
        .row_ready(row_ready)
    );

    rob_row_retire #(
        .ROWS(ROWS), .RETIRE_MAX(RETIRE_MAX), .ROW_W(ROW_W),
        .CNT_W(CNT_W), .USED_W(USED_W)
    ) u_retire (
        .head     (head_q),
        .used     (used_q),
        .row_ready(row_ready),
        .count    (ret_cnt),
        .free_mask(free_mask)
    );

    // Head row and allocated row count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            used_q <= '0;
        end else begin
            head_q <= ROW_W'(ring_add(int'(head_q), int'(ret_cnt), ROWS));
            used_q <= used_q + USED_W'(new_row_taken) - USED_W'(ret_cnt);
        end
    end

    assign retire_rows = ret_cnt;
    assign retire_head = head_q;
    assign rows_used   = used_q;

endmodule

// File: rtl/rob_row_buffer_chk.sv
// Property checker for rob_row_buffer, attached through bind. Observes the
// ports and the new-row strobe; drives nothing.
module rob_row_buffer_chk #(
    parameter int ROWS       = 16,
    parameter int SLOTS      = 7,
    parameter int RETIRE_MAX = 8,
    parameter int ROW_W      = 4,
    parameter int SLOT_W     = 3,
    parameter int CNT_W      = 4,
    parameter int USED_W     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alloc_valid,
    input logic              alloc_flush,
    input logic              alloc_stall,
    input logic [SLOT_W-1:0] alloc_slot,
    input logic [CNT_W-1:0]  retire_rows,
    input logic [ROW_W-1:0]  retire_head,
    input logic [USED_W-1:0] rows_used,
    input logic              new_row_taken
);

    // R4: stall only when every row is allocated
    a_r4_stall_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_stall |-> (int'(rows_used) == ROWS));

    // R2: redirect-capable instruction lands in the last slot
    a_r2_flush_last_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_flush && !alloc_stall) |-> (int'(alloc_slot) == SLOTS - 1));

    // R6: retire count bounded by limit and by allocated rows
    a_r6_retire_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(retire_rows) <= RETIRE_MAX) && (retire_rows <= rows_used));

    // R7: head advances by the rows reported one edge earlier
    a_r7_head_advance: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (int'(retire_head) ==
            (int'($past(retire_head)) + int'($past(retire_rows))) % ROWS));

    // R7: row count follows new rows taken and rows freed
    a_r7_used_track: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (int'(rows_used) == int'($past(rows_used))
            + int'($past(new_row_taken)) - int'($past(retire_rows))));

endmodule

bind rob_row_buffer rob_row_buffer_chk #(
    .ROWS(ROWS), .SLOTS(SLOTS), .RETIRE_MAX(RETIRE_MAX), .ROW_W(ROW_W),
    .SLOT_W(SLOT_W), .CNT_W(CNT_W), .USED_W(USED_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_valid  (alloc_valid),
    .alloc_flush  (alloc_flush),
    .alloc_stall  (alloc_stall),
    .alloc_slot   (alloc_slot),
    .retire_rows  (retire_rows),
    .retire_head  (retire_head),
    .rows_used    (rows_used),
    .new_row_taken(new_row_taken)
);

// File: tb/sim_rob_row_buffer.sv
// Bench for rob_row_buffer: directed corner cases plus seeded random traffic,
// compared every cycle against a row-rule model kept in the bench.
module sim_rob_row_buffer;

    localparam int PERIOD = 10;
    localparam int ROWS   = 16;
    localparam int SLOTS  = 7;
    localparam int RMAX   = 8;
    localparam int ROW_W  = 4;
    localparam int SLOT_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_valid = 1'b0;
    logic              alloc_flush = 1'b0;
    logic              alloc_stall;
    logic [ROW_W-1:0]  alloc_row;
    logic [SLOT_W-1:0] alloc_slot;
    logic              cpl_valid = 1'b0;
    logic [ROW_W-1:0]  cpl_row = '0;
    logic [SLOT_W-1:0] cpl_slot = '0;
    logic [3:0]        retire_rows;
    logic [ROW_W-1:0]  retire_head;
    logic [4:0]        rows_used;

    rob_row_buffer u0 (.*);

    always #(PERIOD / 2) clk = ~clk;

    int tests = 0;
    int fails = 0;

    // Row-rule model
    bit m_valid [ROWS];
    bit m_closed[ROWS];
    bit m_occ   [ROWS][SLOTS];
    bit m_done  [ROWS][SLOTS];
    bit m_open;
    int m_cur, m_fill, m_next, m_head, m_used;

    // Last sampled outputs
    int s_stall, s_row, s_slot, s_retire, s_head, s_used;

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit m_ready(int r);
        if (!m_valid[r] || !m_closed[r]) return 0;
        for (int s = 0; s < SLOTS; s++)
            if (m_occ[r][s] && !m_done[r][s]) return 0;
        return 1;
    endfunction

    function automatic int m_retire();
        int n = 0;
        for (int i = 0; i < RMAX; i++) begin
            if (i >= m_used || !m_ready((m_head + i) % ROWS)) break;
            n++;
        end
        return n;
    endfunction

    task automatic m_init();
        for (int r = 0; r < ROWS; r++) begin
            m_valid[r] = 0; m_closed[r] = 0;
            for (int s = 0; s < SLOTS; s++) begin
                m_occ[r][s] = 0; m_done[r][s] = 0;
            end
        end
        m_open = 0; m_cur = 0; m_fill = 0; m_next = 0; m_head = 0; m_used = 0;
    endtask

    // One cycle: drive, sample and compare, then advance the model
    task automatic step(bit v, bit f, bit cv, int cr, int cs);
        int rc, e_row, e_slot;
        bit e_stall;
        @(negedge clk);
        alloc_valid = v; alloc_flush = f;
        cpl_valid = cv; cpl_row = ROW_W'(cr); cpl_slot = SLOT_W'(cs);
        #1;
        s_stall = alloc_stall; s_row = alloc_row; s_slot = alloc_slot;
        s_retire = retire_rows; s_head = retire_head; s_used = rows_used;
        e_stall = !m_open && (m_used == ROWS);
        e_row   = m_open ? m_cur : m_next;
        e_slot  = f ? SLOTS - 1 : (m_open ? m_fill : 0);
        rc      = m_retire();
        chk("R4 stall", s_stall, e_stall);
        if (!e_stall) begin
            chk("R3 alloc_row", s_row, e_row);
            chk("R1 alloc_slot", s_slot, e_slot);
        end
        chk("R6 retire_rows", s_retire, rc);
        chk("R6 retire_head", s_head, m_head);
        chk("R7 rows_used", s_used, m_used);
        @(posedge clk);
        if (cv && cr < ROWS && cs < SLOTS && m_valid[cr] && m_occ[cr][cs])
            m_done[cr][cs] = 1;
        if (v && !e_stall) begin
            if (!m_open) begin
                for (int s = 0; s < SLOTS; s++) begin
                    m_occ[e_row][s] = 0; m_done[e_row][s] = 0;
                end
                m_valid[e_row] = 1; m_closed[e_row] = 0;
                m_cur = e_row; m_next = (m_next + 1) % ROWS; m_used++;
                m_open = 1; m_fill = 0;
            end
            m_occ[e_row][e_slot] = 1; m_done[e_row][e_slot] = 0;
            if (f || e_slot == SLOTS - 1) begin
                m_closed[e_row] = 1; m_open = 0; m_fill = 0;
            end else begin
                m_fill = e_slot + 1;
            end
        end
        for (int i = 0; i < rc; i++) m_valid[(m_head + i) % ROWS] = 0;
        m_head = (m_head + rc) % ROWS;
        m_used -= rc;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; alloc_valid = 0; alloc_flush = 0; cpl_valid = 0;
        repeat (2) @(posedge clk);
        m_init();
        @(negedge clk);
        rst_n = 1;
    endtask

    // Pick an occupied, incomplete slot from the model
    task automatic pick(output int r, output int s, output bit ok);
        int base = $urandom_range(ROWS * SLOTS - 1);
        ok = 0; r = 0; s = 0;
        for (int k = 0; k < ROWS * SLOTS; k++) begin
            int idx = (base + k) % (ROWS * SLOTS);
            if (m_valid[idx / SLOTS] && m_occ[idx / SLOTS][idx % SLOTS]
                && !m_done[idx / SLOTS][idx % SLOTS]) begin
                r = idx / SLOTS; s = idx % SLOTS; ok = 1;
                break;
            end
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1207));
        m_init();

        // R9: reset state
        do_reset();
        #1;
        chk("R9 rows_used", rows_used, 0);
        chk("R9 stall", alloc_stall, 0);
        chk("R9 retire_rows", retire_rows, 0);
        chk("R9 retire_head", retire_head, 0);
        chk("R9 alloc_row", alloc_row, 0);

        // R8: completions to a free row and to an unused slot are ignored
        step(0, 0, 1, 0, 0);
        step(1, 0, 0, 0, 0);
        step(1, 1, 1, 0, 3);
        step(0, 0, 1, 0, 6);
        step(0, 0, 0, 0, 0);
        chk("R8 stale completion ignored", s_retire, 0);
        step(0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0);
        chk("R5 row ready after all slots", s_retire, 1);

        // R2: add, mov, store share one row; next instruction opens row 1
        do_reset();
        step(1, 0, 0, 0, 0);
        chk("R1 add slot", s_slot, 0);
        step(1, 0, 0, 0, 0);
        chk("R1 mov slot", s_slot, 1);
        step(1, 1, 0, 0, 0);
        chk("R2 store slot", s_slot, 6);
        chk("R2 store row", s_row, 0);
        step(1, 0, 0, 0, 0);
        chk("R3 next row", s_row, 1);
        chk("R1 next slot", s_slot, 0);
        step(0, 0, 0, 0, 0);
        chk("R7 two rows used", s_used, 2);

        // R4: only flush-capable instructions fill ROWS rows, then stall
        do_reset();
        for (int i = 0; i < ROWS; i++) step(1, 1, 0, 0, 0);
        step(1, 1, 0, 0, 0);
        chk("R4 stall at capacity", s_stall, 1);
        chk("R4 rows at capacity", s_used, ROWS);
        step(1, 0, 0, 0, 0);
        chk("R4 still stalled", s_stall, 1);
        // R5: complete tail rows first so the head row gates retirement
        for (int r = ROWS - 1; r >= 1; r--) step(0, 0, 1, r, 6);
        step(0, 0, 0, 0, 0);
        chk("R5 blocked by head row", s_retire, 0);
        step(0, 0, 1, 0, 6);
        step(0, 0, 0, 0, 0);
        chk("R6 limit per cycle", s_retire, RMAX);
        step(0, 0, 0, 0, 0);
        chk("R6 remaining rows", s_retire, ROWS - RMAX);
        chk("R7 head after eight", s_head, RMAX);
        step(0, 0, 0, 0, 0);
        chk("R7 all freed", s_used, 0);

        // Random traffic against the model
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            int r, s;
            bit ok, v, f, cv;
            v = ($urandom_range(99) < 60);
            f = ($urandom_range(99) < 30);
            cv = 0;
            if ($urandom_range(99) < 75) begin
                pick(r, s, ok);
                cv = ok;
            end else begin
                r = $urandom_range(ROWS - 1);
                s = $urandom_range(SLOTS);
                cv = 1;
            end
            step(v, f, cv, r, s);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule